// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse-Width Modulator

This block produces one pulse-width-modulated output from a single 32-bit control word. An internal prescaler divides the input clock into ticks. A frame counter advances once per tick and spans 256 ticks. Within each frame the output starts low. It goes high once the frame counter reaches the programmed low-time value and stays high for the rest of the frame. Software programs the word through a plain write strobe and reads it back continuously on a read bus. Fields are changed by read-modify-write.

The control word carries a run bit, a parked-level bit, an 8-bit divisor and an 8-bit low-time count. While the run bit is clear, the output sits at the parked level. While running, divisor and low-time changes are held back until the current frame finishes, so no pulse is cut short. Setting the run bit restarts the prescaler and frame counter from zero.

Top module: `pwm8_prescaled`

## Requirements
- R1: A synchronous active-high reset clears the whole control word to zero, so the read bus shows 0 and the output is low.
- R2: On a write, bits 31, 30 and 15:0 are stored exactly as written and read back unchanged. Bits 29:16 always read as zero and ignore writes, so writing 0xFFFFFFFF reads back 0xC000FFFF.
- R3: While bit 31 (run) is clear, the output equals bit 30 (parked level), from the cycle after the write edge.
- R4: While running, one frame lasts 256×D clock cycles, where D is the value in bits 15:8 for values 1 to 255, and D is 256 when the field is 0.
- R5: With L the value in bits 7:0 and f the frame position (0 to 255, advancing every D cycles), the output is low while f < L and high otherwise. L=0 gives a constant high and L=255 gives one high tick per frame.
- R6: When run goes from 0 to 1, the output stays at the parked level for one cycle. From the next cycle on, frame position 0 starts with a cleared prescaler, so the first frame is complete even if the block was stopped mid-frame.
- R7: Divisor or low-time writes made while running take effect only at the first frame boundary after the write. The frame in progress finishes with the old values.
- R8: Clearing run while a frame is in progress switches the output to the parked level in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Current control word, with reserved bits reading zero |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench compares the output cycle by cycle against an arithmetic model. It covers the low-time extremes 0, 1 and 255, several small divisors, and divisor 0, whose full 65,536-cycle frame is checked. Getting 0 as divide-by-1 would show a period 256 times too short. Mid-frame writes to divisor and low-time are checked to be held to the frame boundary; a design applying them at once would misshape the rest of the current frame. A stop issued mid-frame and followed by a restart is checked for an immediate parked level and then a fresh, complete frame; a design that kept its counters would resume part-way through the frame. Reserved-bit masking and parked-level tracking are checked at the read bus and the output pin.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned RUN_POS  = 31;
   localparam int unsigned PARK_POS = 30;

   // Bits that hold state: run, parked level and the two packed fields.
   function automatic logic [REG_W-1:0] keep_mask(input int unsigned fw);
      logic [REG_W-1:0] m;
      m = '0;
      m[RUN_POS]  = 1'b1;
      m[PARK_POS] = 1'b1;
      for (int unsigned i = 0; i < 2 * fw; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pwm8_ctrl_reg.sv
module pwm8_ctrl_reg #(
   parameter int unsigned FIELD_W = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [pwm8_pkg::REG_W-1:0]  wr_data,
   output logic [pwm8_pkg::REG_W-1:0]  cfg_q
);
   localparam logic [pwm8_pkg::REG_W-1:0] KEEP = pwm8_pkg::keep_mask(FIELD_W);

   for (genvar b = 0; b < pwm8_pkg::REG_W; b++) begin : g_bit
      if (KEEP[b]) begin : g_store
         logic q;
         always_ff @(posedge clk) begin
            if (rst)        q <= 1'b0;
            else if (wr_en) q <= wr_data[b];
         end
         assign cfg_q[b] = q;
      end else begin : g_rsvd
         assign cfg_q[b] = 1'b0;
      end
   end
endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler #(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run,
   input  logic [FIELD_W-1:0] div,
   output logic               tick
);
   logic [FIELD_W-1:0] cnt_q;
   logic [FIELD_W-1:0] term;

   // Field value 0 wraps to all ones here, which gives the full 2**FIELD_W division.
   assign term = div - FIELD_W'(1);
   assign tick = run && (cnt_q == term);

   always_ff @(posedge clk) begin
      if (rst || !run) cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + FIELD_W'(1);
   end
endmodule

// File: rtl/pwm8_frame.sv
module pwm8_frame #(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run,
   input  logic               tick,
   input  logic [FIELD_W-1:0] div_in,
   input  logic [FIELD_W-1:0] low_in,
   output logic [FIELD_W-1:0] frame_q,
   output logic [FIELD_W-1:0] div_sh,
   output logic [FIELD_W-1:0] low_sh,
   output logic               level_hi
);
   logic wrap;
   assign wrap     = tick && (&frame_q);
   assign level_hi = (frame_q >= low_sh);

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q <= '0;
         div_sh  <= '0;
         low_sh  <= '0;
      end else if (!run) begin
         frame_q <= '0;
         div_sh  <= div_in;
         low_sh  <= low_in;
      end else if (tick) begin
         frame_q <= frame_q + FIELD_W'(1);
         if (wrap) begin
            div_sh <= div_in;
            low_sh <= low_in;
         end
      end
   end
endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled #(
   parameter int unsigned FIELD_W = 8
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic        pwm_out
);
   localparam int unsigned DIV_LSB = FIELD_W;

   if (FIELD_W < 2 || 2 * FIELD_W > pwm8_pkg::PARK_POS) begin : g_bad_width
      $error("FIELD_W must leave room below the parked-level bit");
   end

   logic [31:0]        cfg;
   logic               run_en;
   logic               park_lvl;
   logic               run_q;
   logic               tick;
   logic [FIELD_W-1:0] frame_q;
   logic [FIELD_W-1:0] div_sh;
   logic [FIELD_W-1:0] low_sh;
   logic               level_hi;

   pwm8_ctrl_reg #(.FIELD_W(FIELD_W)) reg_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg)
   );

   assign run_en   = cfg[pwm8_pkg::RUN_POS];
   assign park_lvl = cfg[pwm8_pkg::PARK_POS];
   assign rd_data  = cfg;

   // run_q lags the run bit by one cycle; the gap clears both counters on a start.
   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= run_en;
   end

   pwm8_prescaler #(.FIELD_W(FIELD_W)) pre_i (
      .clk(clk), .rst(rst), .run(run_q), .div(div_sh), .tick(tick)
   );

   pwm8_frame #(.FIELD_W(FIELD_W)) frm_i (
      .clk(clk), .rst(rst), .run(run_q), .tick(tick),
      .div_in(cfg[DIV_LSB +: FIELD_W]), .low_in(cfg[0 +: FIELD_W]),
      .frame_q(frame_q), .div_sh(div_sh), .low_sh(low_sh), .level_hi(level_hi)
   );

   assign pwm_out = (run_en && run_q) ? level_hi : park_lvl;
endmodule

// File: rtl/pwm8_prescaled_chk.sv
module pwm8_prescaled_chk #(
   parameter int unsigned FIELD_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_en,
   input logic [31:0]        wr_data,
   input logic [31:0]        rd_data,
   input logic               pwm_out,
   input logic               run_q,
   input logic               tick,
   input logic [FIELD_W-1:0] frame_q,
   input logic [FIELD_W-1:0] low_sh
);
   localparam logic [31:0] KEEP = pwm8_pkg::keep_mask(FIELD_W);

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (rd_data == 32'h0 && !pwm_out)); // R1
   AST_WRITE_BACK: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (rd_data == ($past(wr_data) & KEEP))); // R2
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd_data[29:16] == 14'h0); // R2
   AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (rst)
      !rd_data[31] |-> (pwm_out == rd_data[30])); // R3
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
      (run_q && $past(run_q) && !$past(tick)) |-> $stable(frame_q)); // R4
   AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (run_q && $past(run_q) && !($past(tick) && (&$past(frame_q)))) |-> $stable(low_sh)); // R7
endmodule

bind pwm8_prescaled pwm8_prescaled_chk #(.FIELD_W(FIELD_W)) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
   .pwm_out(pwm_out), .run_q(run_q), .tick(tick), .frame_q(frame_q), .low_sh(low_sh)
);

// File: tb/pwm8_prescaled_tb.sv
module pwm8_prescaled_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;

   int total = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   pwm8_prescaled dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pwm_out(pwm_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         fails = fails + 1;
         total = total + 1;
         $display("FAIL watchdog actual=%0d expected<190000", cycles);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   function automatic logic [31:0] word(input bit run, input bit park, input int d, input int l);
      return {run, park, 14'h0, 8'(d), 8'(l)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge after the write edge.
   task automatic wr(input logic [31:0] v);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Stop, start with (d0,l0), optionally rewrite to (d1,l1) at sample tsw, compare len samples.
   task automatic run_seq(input int d0, input int l0, input int d1, input int l1,
                          input int tsw, input int len, input string req);
      int de0, de1, p0, bad, bad_t;
      logic expv, bad_exp;
      de0 = (d0 == 0) ? 256 : d0;
      de1 = (d1 == 0) ? 256 : d1;
      p0  = 256 * de0;
      bad = 0; bad_t = 0; bad_exp = 1'b0;
      wr(word(1'b0, 1'b0, d0, l0));
      wr(word(1'b1, 1'b0, d0, l0));
      @(negedge clk);
      for (int t = 0; t < len; t++) begin
         if (tsw < 0 || t < p0) expv = ((t / de0) % 256) >= l0;
         else                   expv = (((t - p0) / de1) % 256) >= l1;
         if (pwm_out !== expv) begin
            if (bad == 0) begin bad_t = t; bad_exp = expv; end
            bad++;
         end
         if (t == tsw) begin wr_en = 1'b1; wr_data = word(1'b1, 1'b0, d1, l1); end
         else wr_en = 1'b0;
         @(negedge clk);
      end
      wr_en = 1'b0;
      if (bad != 0) $display("  first mismatch of %s at sample %0d", req, bad_t);
      chk(bad == 0, req, 32'(bad == 0 ? bad_exp : ~bad_exp), 32'(bad_exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(rd_data == 32'h0, "R1 word after reset", rd_data, 32'h0);
      chk(pwm_out == 1'b0, "R1 output after reset", 32'(pwm_out), 32'h0);

      wr(32'hFFFF_FFFF);
      chk(rd_data == 32'hC000_FFFF, "R2 reserved masking", rd_data, 32'hC000_FFFF);
      wr(32'h4000_A55A);
      chk(rd_data == 32'h4000_A55A, "R2 exact readback", rd_data, 32'h4000_A55A);
      chk(pwm_out == 1'b1, "R3 parked high", 32'(pwm_out), 32'h1);
      wr(32'h0000_3C0F);
      chk(pwm_out == 1'b0, "R3 parked low", 32'(pwm_out), 32'h0);

      run_seq(1, 0,   1, 0,   -1, 512,   "R5 low-time 0 constant high");
      run_seq(1, 1,   1, 1,   -1, 512,   "R5 low-time 1");
      run_seq(1, 128, 1, 128, -1, 512,   "R5 low-time 128");
      run_seq(1, 255, 1, 255, -1, 512,   "R5 low-time 255 single tick");
      run_seq(2, 37,  2, 37,  -1, 1024,  "R4 divisor 2");
      run_seq(3, 200, 3, 200, -1, 1536,  "R4 divisor 3");
      run_seq(5, 128, 5, 128, -1, 2560,  "R4 divisor 5 two frames");
      run_seq(0, 250, 0, 250, -1, 65536, "R4 divisor field 0 is 256");
      run_seq(1, 0,   1, 200, 100, 768,  "R7 low-time change at boundary");
      run_seq(1, 0,   2, 100, 40, 768,   "R7 divisor change at boundary");

      // Stop mid-frame with parked high, then restart.
      run_seq(1, 0, 1, 0, -1, 77, "R5 prefix before stop");
      wr(word(1'b0, 1'b1, 1, 0));
      chk(pwm_out == 1'b1, "R8 stop goes to parked level", 32'(pwm_out), 32'h1);
      wr(word(1'b1, 1'b1, 1, 10));
      chk(pwm_out == 1'b1, "R6 start cycle parked", 32'(pwm_out), 32'h1);
      begin
         int bad;
         bad = 0;
         for (int t = 0; t < 256; t++) begin
            @(negedge clk);
            if (pwm_out !== (t >= 10)) bad++;
         end
         chk(bad == 0, "R6 restart gives full first frame", 32'(bad), 32'h0);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule